// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block gives a processor a bank of up to 24 general-purpose pins behind a small word-addressed register bus. Each pin can be set up as an input or an output. An output pin drives a latched level and its output enable. An input pin is sampled through a synchroniser, and its level can be read back. The controller also drives an open-drain select vector and a pull-up select vector for the pad ring, and does nothing else with them.

Input pins are watched for edges. Each pin can look for a rising edge, a falling edge, or either edge. A detected edge sets a sticky status bit, and software clears that bit by writing 1 to it. Status bits whose enable bits are set feed a two-state global event machine. That machine has two states, GEV_IDLE and GEV_PEND, and two transitions. The transition `raise` goes from GEV_IDLE to GEV_PEND when any enabled status bit is set. The transition `ack` goes from GEV_PEND to GEV_IDLE on a write of 1 to the acknowledge bit, but only if no enabled status bit is still set. While the machine is in GEV_PEND and the global enable bit is set, the interrupt output is high.

Pins 2 to 5 are wired as outputs only. A single write to the software-reset word returns every register to its reset value.

Top module: `pio_edge_ctrl`

## Requirements
- R1: After reset the direction word (index 1) reads 0x00FFFFC3. The output latch, edge, status, enable, open-drain, pull-up and global registers all read 0. `irq` is 0 and `pad_oe` is 0x00003C.
- R2: In direction word index 1, a bit value of 1 makes the pin an input and 0 makes it an output. `pad_oe` is the inverse of the direction bits. Direction bits 2 to 5 always read 0, and bits 31:24 of every per-pin word read 0.
- R3: A write to data word index 0 sets the output latch, and `pad_out` shows the latch. A read of word 0 returns the synchronised pad level for input pins and the latch value for output pins. A pad change shows up in the read value two clock cycles later.
- R4: When a pin's both-edges bit (word 7) is 0, its mode bit (word 2) chooses the edge: 1 detects rising edges and 0 detects falling edges. The opposite edge does not set the status bit.
- R5: When a pin's both-edges bit is 1, a rising edge and a falling edge each set the pin's status bit, whatever the mode bit says.
- R6: Status bits (word 5) are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an edge arrives in the same cycle as a clear of that bit, the bit stays set.
- R7: A status bit whose enable bit (word 6) is 0 never moves the global event machine.
- R8: The global group uses bit 4 of three words. Word 8 is the read-only event state. Word 9 is write-1 acknowledge and reads 0. Word 10 is the enable. `irq` is high exactly when the event state is GEV_PEND and the enable is set. An acknowledge takes effect only when no enabled status bit is still set.
- R9: Word 3 drives `pad_od` and word 4 drives `pad_pu`. Only bits 23:0 are kept in each.
- R10: Writing a word with bit 0 set to index 11 returns every register to its R1 value. Writing 0 there has no effect. Word 11 reads 0.
- R11: A pin whose direction bit is 0, which includes pins 2 to 5, never sets its status bit. A read of pins 2 to 5 never returns the pad level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register word at `bus_addr` |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_in | input | 24 | Pad levels from the pins |
| pad_out | output | 24 | Output latch levels |
| pad_oe | output | 24 | Output enables, 1 = drive |
| pad_od | output | 24 | Open-drain select per pin |
| pad_pu | output | 24 | Pull-up select per pin |
| irq | output | 1 | Merged edge interrupt |

## Verification
The edge detector is driven with rising-only, falling-only and both-edges setups on neighbouring pins that share one pad vector. These runs show whether polarity is chosen per pin or by one shared bit. Toggling pads on the fixed-output pins and on pins with outputs enabled shows whether the direction gate in front of the status bits is present. A clear that lands on the same edge as a new event, together with an acknowledge issued while an enabled bit is still pending, shows whether the clear takes priority over the set and whether the event machine leaves GEV_PEND too early. Writes with the upper byte set, and a soft reset written with 0 and then with 1, cover the bits that are not implemented and the trigger condition of the reset.

// File: rtl/pio_pkg.sv
package pio_pkg;

    // Register word indices; the data..both order is decoded by software.
    localparam int REG_DATA = 0;
    localparam int REG_DIR  = 1;
    localparam int REG_MODE = 2;
    localparam int REG_OD   = 3;
    localparam int REG_PU   = 4;
    localparam int REG_STS  = 5;
    localparam int REG_EN   = 6;
    localparam int REG_BOTH = 7;
    localparam int REG_GSTS = 8;
    localparam int REG_GCLR = 9;
    localparam int REG_GEN  = 10;
    localparam int REG_SRST = 11;
    localparam int NUM_REGS = 12;

    typedef enum logic [0:0] {
        GEV_IDLE = 1'b0,
        GEV_PEND = 1'b1
    } gev_state_e;

endpackage

// File: rtl/pio_input_stage.sv
module pio_input_stage #(
    parameter int NPINS       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] level_o,
    output logic [NPINS-1:0] rise_o,
    output logic [NPINS-1:0] fall_o
);

    logic [SYNC_STAGES-1:0][NPINS-1:0] chain_q;
    logic [NPINS-1:0]                  last_q;

    // Synchroniser chain plus one history stage for edge comparison.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= '0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], pad_in};
            last_q  <= chain_q[SYNC_STAGES-1];
        end
    end

    assign level_o = chain_q[SYNC_STAGES-1];
    assign rise_o  = level_o & ~last_q;
    assign fall_o  = ~level_o & last_q;

endmodule

// File: rtl/pio_irq_merge.sv
module pio_irq_merge
    import pio_pkg::*;
#(
    parameter int NPINS = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic [NPINS-1:0] sts_i,
    input  logic [NPINS-1:0] en_i,
    input  logic             ack_i,
    input  logic             gen_i,
    output logic             gsts_o,
    output logic             irq_o
);

    gev_state_e state_q, state_d;
    logic       pending;

    assign pending = |(sts_i & en_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GEV_IDLE: if (pending)            state_d = GEV_PEND; // raise
            GEV_PEND: if (ack_i && !pending)  state_d = GEV_IDLE; // ack
            default:                          state_d = GEV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state_q <= GEV_IDLE;
        else if (soft_clr) state_q <= GEV_IDLE;
        else               state_q <= state_d;
    end

    always_comb begin
        gsts_o = (state_q == GEV_PEND);
        irq_o  = gsts_o && gen_i;
    end

endmodule

// File: rtl/pio_edge_ctrl.sv
module pio_edge_ctrl
    import pio_pkg::*;
#(
    parameter int NPINS       = 24,
    parameter int DW          = 32,
    parameter int AW          = 4,
    parameter int SYNC_STAGES = 2,
    parameter int FIX_LO      = 2,
    parameter int FIX_HI      = 5,
    parameter int GEV_BIT     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_od,
    output logic [NPINS-1:0] pad_pu,
    output logic             irq
);

    function automatic logic [NPINS-1:0] fixed_out_mask();
        logic [NPINS-1:0] m;
        m = '0;
        for (int i = FIX_LO; i <= FIX_HI; i++) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [NPINS-1:0] FIXED_OUT = fixed_out_mask();
    localparam logic [NPINS-1:0] DIR_RST   = ~FIXED_OUT;

    logic [NUM_REGS-1:0] wsel;
    logic [NPINS-1:0]    wlo;
    logic                unused_hi;
    logic                soft_clr, ack;

    logic [NPINS-1:0] out_q, dir_q, mode_q, od_q, pu_q, sts_q, en_q, both_q;
    logic             gen_q, gsts;
    logic [NPINS-1:0] level, rise, fall, pin_ev, data_view;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_wsel
        assign wsel[r] = bus_wr && (bus_addr == AW'(r));
    end

    assign wlo       = bus_wdata[NPINS-1:0];
    assign unused_hi = ^bus_wdata[DW-1:NPINS];
    assign soft_clr  = wsel[REG_SRST] && bus_wdata[0];
    assign ack       = wsel[REG_GCLR] && bus_wdata[GEV_BIT];

    pio_input_stage #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .pad_in  (pad_in),
        .level_o (level),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    // Per-pin edge selection, gated by direction.
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        assign pin_ev[p] = dir_q[p] &
            (both_q[p] ? (rise[p] | fall[p]) : (mode_q[p] ? rise[p] : fall[p]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0; dir_q <= DIR_RST; mode_q <= '0; od_q <= '0;
            pu_q  <= '0; sts_q <= '0;      en_q   <= '0; both_q <= '0;
            gen_q <= 1'b0;
        end else if (soft_clr) begin
            out_q <= '0; dir_q <= DIR_RST; mode_q <= '0; od_q <= '0;
            pu_q  <= '0; sts_q <= '0;      en_q   <= '0; both_q <= '0;
            gen_q <= 1'b0;
        end else begin
            if (wsel[REG_DATA]) out_q  <= wlo;
            if (wsel[REG_DIR])  dir_q  <= wlo & ~FIXED_OUT;
            if (wsel[REG_MODE]) mode_q <= wlo;
            if (wsel[REG_OD])   od_q   <= wlo;
            if (wsel[REG_PU])   pu_q   <= wlo;
            if (wsel[REG_EN])   en_q   <= wlo;
            if (wsel[REG_BOTH]) both_q <= wlo;
            if (wsel[REG_GEN])  gen_q  <= bus_wdata[GEV_BIT];
            sts_q <= (sts_q & ~(wsel[REG_STS] ? wlo : '0)) | pin_ev;
        end
    end

    pio_irq_merge #(.NPINS(NPINS)) u_gev (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .sts_i    (sts_q),
        .en_i     (en_q),
        .ack_i    (ack),
        .gen_i    (gen_q),
        .gsts_o   (gsts),
        .irq_o    (irq)
    );

    assign data_view = (dir_q & level) | (~dir_q & out_q);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(REG_DATA): bus_rdata = DW'(data_view);
            AW'(REG_DIR):  bus_rdata = DW'(dir_q);
            AW'(REG_MODE): bus_rdata = DW'(mode_q);
            AW'(REG_OD):   bus_rdata = DW'(od_q);
            AW'(REG_PU):   bus_rdata = DW'(pu_q);
            AW'(REG_STS):  bus_rdata = DW'(sts_q);
            AW'(REG_EN):   bus_rdata = DW'(en_q);
            AW'(REG_BOTH): bus_rdata = DW'(both_q);
            AW'(REG_GSTS): bus_rdata = DW'(gsts)  << GEV_BIT;
            AW'(REG_GEN):  bus_rdata = DW'(gen_q) << GEV_BIT;
            default:       bus_rdata = '0;
        endcase
    end

    assign pad_out = out_q;
    assign pad_oe  = ~dir_q;
    assign pad_od  = od_q;
    assign pad_pu  = pu_q;

endmodule

// File: rtl/pio_edge_ctrl_chk.sv
module pio_edge_ctrl_chk
    import pio_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int AW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [AW-1:0]    bus_addr,
    input logic             soft_clr,
    input logic             ack,
    input logic [NPINS-1:0] sts,
    input logic [NPINS-1:0] en,
    input logic [NPINS-1:0] dir,
    input logic             gen,
    input logic             gsts,
    input logic             irq
);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_wr && bus_addr == AW'(REG_STS)) && !soft_clr) |=> ((~sts & $past(sts)) == '0));

    assert_input_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts & ~$past(sts) & ~$past(dir)) == '0));

    assert_soft_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (sts == '0 && !irq && !gen && !gsts));

    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !gen |-> !irq);

    assert_raise_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gsts) |-> $past(|(sts & en)));

    assert_pend_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gsts && !ack && !soft_clr) |=> gsts);

endmodule

bind pio_edge_ctrl pio_edge_ctrl_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .soft_clr (soft_clr),
    .ack      (ack),
    .sts      (sts_q),
    .en       (en_q),
    .dir      (dir_q),
    .gen      (gen_q),
    .gsts     (gsts),
    .irq      (irq)
);

// File: tb/pio_edge_ctrl_bench.sv
module pio_edge_ctrl_bench;

    localparam int A_DATA = 0, A_DIR = 1, A_MODE = 2, A_OD = 3, A_PU = 4, A_STS = 5;
    localparam int A_EN = 6, A_BOTH = 7, A_GSTS = 8, A_GCLR = 9, A_GEN = 10, A_SRST = 11;
    localparam int K_REG = 0, K_OUT = 1, K_OE = 2, K_IRQ = 3, K_OD = 4, K_PU = 5;

    typedef struct {
        int          kind;
        int          addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [23:0] pad_in = 24'h000001;
    logic [23:0] pad_out, pad_oe, pad_od, pad_pu;
    logic        irq;

    item_t q[$];
    int    pushed = 0, served = 0, nchk = 0, nfail = 0;
    bit    done = 1'b0;

    pio_edge_ctrl u_pio_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od), .pad_pu(pad_pu), .irq(irq)
    );

    always #4 clk = ~clk;

    // Monitor: pops expected items and compares against the design.
    initial begin
        forever begin
            item_t it;
            logic [31:0] got;
            wait (q.size() != 0);
            it = q.pop_front();
            case (it.kind)
                K_REG: begin bus_addr = it.addr[3:0]; #1; got = bus_rdata; end
                K_OUT: got = {8'h0, pad_out};
                K_OE:  got = {8'h0, pad_oe};
                K_OD:  got = {8'h0, pad_od};
                K_PU:  got = {8'h0, pad_pu};
                default: got = {31'h0, irq};
            endcase
            nchk++;
            if (got !== it.exp) begin
                nfail++;
                $display("FAIL %s: kind %0d addr %0d got %h expected %h",
                         it.tag, it.kind, it.addr, got, it.exp);
            end
            served++;
        end
    end

    task automatic expect_val(input int kind, input int addr, input logic [31:0] exp,
                              input string tag);
        item_t it;
        it.kind = kind; it.addr = addr; it.exp = exp; it.tag = tag;
        q.push_back(it);
        pushed++;
        wait (served == pushed);
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        bus_wr = 1'b1; bus_addr = addr[3:0]; bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(6);
        // R1 reset state
        expect_val(K_REG, A_DIR,  32'h00FFFFC3, "R1 dir reset");
        expect_val(K_REG, A_DATA, 32'h00000001, "R1 data reset");
        expect_val(K_REG, A_STS,  32'h0, "R1 sts reset");
        expect_val(K_REG, A_GSTS, 32'h0, "R1 gsts reset");
        expect_val(K_IRQ, 0, 32'h0, "R1 irq reset");
        expect_val(K_OE,  0, 32'h3C, "R1 pad_oe reset");
        expect_val(K_OUT, 0, 32'h0, "R1 pad_out reset");
        // R2 direction
        wr(A_DIR, 32'hFFFFFFFF);
        expect_val(K_REG, A_DIR, 32'h00FFFFC3, "R2 fixed outputs and upper bits");
        wr(A_DIR, 32'h0);
        expect_val(K_REG, A_DIR, 32'h0, "R2 all outputs");
        expect_val(K_OE, 0, 32'h00FFFFFF, "R2 oe all");
        expect_val(K_REG, A_DATA, 32'h0, "R3 output pin reads latch");
        wr(A_DIR, 32'h00FF00FF);
        expect_val(K_REG, A_DIR, 32'h00FF00C3, "R2 mixed");
        expect_val(K_OE, 0, 32'h00FF3C, "R2 oe mixed");
        wr(A_DIR, 32'h00FFFFC3);
        // R3 data
        wr(A_DATA, 32'hAB00003C);
        expect_val(K_OUT, 0, 32'h3C, "R3 pad_out");
        expect_val(K_REG, A_DATA, 32'h3D, "R3 mixed read");
        pad_in = 24'h000081;
        idle(3);
        expect_val(K_REG, A_DATA, 32'hBD, "R3 input follows pad");
        // R11 output-only pins
        wr(A_BOTH, 32'h3C);
        pad_in = 24'h0000BD; idle(3);
        pad_in = 24'h000081; idle(4);
        expect_val(K_REG, A_STS, 32'h0, "R11 no status on output pins");
        wr(A_DATA, 32'h0);
        pad_in = 24'h0000BD; idle(3);
        expect_val(K_REG, A_DATA, 32'h81, "R11 pad not returned on pins 2-5");
        pad_in = 24'h000081; idle(4);
        wr(A_BOTH, 32'h0);
        // R4 polarity
        expect_val(K_REG, A_STS, 32'h0, "R4 rise ignored in falling mode");
        wr(A_MODE, 32'hFF000100);
        expect_val(K_REG, A_MODE, 32'h100, "R4 mode readback");
        pad_in = 24'h000381; idle(4);
        expect_val(K_REG, A_STS, 32'h100, "R4 rising pin set, falling pin not");
        pad_in = 24'h000181; idle(4);
        expect_val(K_REG, A_STS, 32'h300, "R4 falling pin set");
        pad_in = 24'h000081; idle(4);
        expect_val(K_REG, A_STS, 32'h300, "R4 fall ignored in rising mode");
        // R6 sticky / write-1-clear
        wr(A_STS, 32'h100);
        expect_val(K_REG, A_STS, 32'h200, "R6 clear one bit");
        wr(A_STS, 32'h0);
        expect_val(K_REG, A_STS, 32'h200, "R6 write zero keeps");
        wr(A_STS, 32'h200);
        expect_val(K_REG, A_STS, 32'h0, "R6 clear other");
        pad_in = 24'h000181; idle(2);
        wr(A_STS, 32'h100);
        expect_val(K_REG, A_STS, 32'h100, "R6 edge beats clear");
        wr(A_STS, 32'hFFFFFFFF);
        expect_val(K_REG, A_STS, 32'h0, "R6 clear all");
        // R5 both edges
        wr(A_BOTH, 32'h400);
        pad_in = 24'h000581; idle(4);
        expect_val(K_REG, A_STS, 32'h400, "R5 rise in any-edge");
        wr(A_STS, 32'h400);
        pad_in = 24'h000181; idle(4);
        expect_val(K_REG, A_STS, 32'h400, "R5 fall in any-edge");
        // R7 / R8 global group
        expect_val(K_REG, A_GSTS, 32'h0, "R7 disabled status ignored");
        wr(A_EN, 32'h400); idle(2);
        expect_val(K_REG, A_GSTS, 32'h10, "R8 global state bit 4");
        expect_val(K_IRQ, 0, 32'h0, "R8 irq masked by global enable");
        wr(A_GEN, 32'hFFFFFFFF);
        expect_val(K_REG, A_GEN, 32'h10, "R8 enable bit only");
        expect_val(K_IRQ, 0, 32'h1, "R8 irq asserted");
        wr(A_GCLR, 32'h10);
        expect_val(K_REG, A_GSTS, 32'h10, "R8 ack blocked while pending");
        expect_val(K_REG, A_GCLR, 32'h0, "R8 clear word reads 0");
        wr(A_STS, 32'h400);
        wr(A_GCLR, 32'h10);
        expect_val(K_REG, A_GSTS, 32'h0, "R8 ack after pin clear");
        expect_val(K_IRQ, 0, 32'h0, "R8 irq dropped");
        wr(A_BOTH, 32'hC00);
        pad_in = 24'h000981; idle(4);
        expect_val(K_REG, A_STS, 32'h800, "R7 unenabled pin records");
        expect_val(K_REG, A_GSTS, 32'h0, "R7 unenabled pin no global");
        expect_val(K_IRQ, 0, 32'h0, "R7 no irq");
        pad_in = 24'h000D81; idle(5);
        expect_val(K_REG, A_STS, 32'hC00, "R8 enabled pin records");
        expect_val(K_IRQ, 0, 32'h1, "R8 edge to irq");
        // R9 pad control vectors
        wr(A_OD, 32'hFF00000F);
        expect_val(K_OD, 0, 32'hF, "R9 pad_od");
        expect_val(K_REG, A_OD, 32'hF, "R9 od readback");
        wr(A_PU, 32'h12345678);
        expect_val(K_PU, 0, 32'h345678, "R9 pad_pu");
        expect_val(K_REG, A_PU, 32'h00345678, "R9 pu readback");
        // R10 soft reset
        wr(A_DATA, 32'h3C);
        wr(A_SRST, 32'h0);
        expect_val(K_REG, A_OD, 32'hF, "R10 zero write no effect");
        wr(A_SRST, 32'h1);
        expect_val(K_REG, A_DIR, 32'h00FFFFC3, "R10 dir restored");
        expect_val(K_REG, A_OD, 32'h0, "R10 od cleared");
        expect_val(K_PU, 0, 32'h0, "R10 pad_pu cleared");
        expect_val(K_OUT, 0, 32'h0, "R10 latch cleared");
        expect_val(K_REG, A_STS, 32'h0, "R10 status cleared");
        expect_val(K_REG, A_EN, 32'h0, "R10 enable cleared");
        expect_val(K_REG, A_BOTH, 32'h0, "R10 both cleared");
        expect_val(K_REG, A_MODE, 32'h0, "R10 mode cleared");
        expect_val(K_REG, A_GEN, 32'h0, "R10 global enable cleared");
        expect_val(K_REG, A_GSTS, 32'h0, "R10 global state cleared");
        expect_val(K_IRQ, 0, 32'h0, "R10 irq low");
        expect_val(K_REG, A_SRST, 32'h0, "R10 reset word reads 0");
        expect_val(K_REG, A_DATA, 32'h00000D81, "R10 pads still visible");
        done = 1'b1;
        summary();
        $finish;
    end

endmodule